// File: doc/BRIEF.md
# Dynamic Defective Pixel Corrector

This block sits on a raw Bayer pixel stream and repairs isolated bad pixels as they pass. A pixel can be dead (stuck low), hot (stuck high) or stuck somewhere in between, and its fault may come and go with temperature or exposure. For that reason nothing is stored about where the faults are. Each pixel is judged afresh in every frame against the eight samples of its own colour that lie two rows and/or two columns away.

The reference value is the median of those eight samples, taken as the floor of the mean of the two middle values. A pixel that rises above the reference by more than the hot threshold is replaced by the reference. So is a pixel that falls below it by more than the cold threshold. Every other pixel, and every pixel within two positions of the image edge, leaves the block unchanged.

Four line buffers and a 5x5 register window hold the neighbourhood. A small state machine sequences each frame:

- **ST_IDLE** waits for a start-of-frame pixel. The transition *start* takes that pixel and moves to ST_ACTIVE.
- **ST_ACTIVE** accepts one pixel per valid cycle. The transition *last_in*, on the final pixel of the frame, moves to ST_DRAIN.
- **ST_DRAIN** pushes zero padding through the window on every cycle until the last centre has been produced. The transition *drained* then moves to ST_DONE.
- **ST_DONE** lasts one cycle. It latches the frame's correction count, and the transition *rearm* returns to ST_IDLE.

Top module: `dpc_corrector`

## Requirements
- R1: After reset, out_valid, out_fix and defect_count are all 0.
- R2: For each pixel accepted, exactly one output is produced, and outputs come in raster order.
- R3: An interior pixel whose value exceeds the same-colour median by more than thr_hot is output as the median, with out_fix=1. The median is floor((a+b)/2), where a and b are the 4th and 5th smallest of the eight samples at row and column offsets in {-2,0,+2}, excluding the centre.
- R4: An interior pixel that is below the median by more than thr_cold is output as the median, with out_fix=1.
- R5: An interior pixel whose distance from the median is no more than the threshold on its side, including exact equality, is output unchanged with out_fix=0.
- R6: A pixel in row 0, row 1, row IMG_H-2 or row IMG_H-1, or in column 0, column 1, column IMG_W-2 or column IMG_W-1, is output unchanged with out_fix=0.
- R7: A frame starts only on in_valid=1 together with in_sof=1 while the block is idle. In idle, input with in_sof=0 is ignored. After the last pixel of a frame, input is ignored until the drain has finished, which takes 2*IMG_W+3 cycles.
- R8: defect_count changes only in the cycle after a frame's drain ends. It then holds the number of pixels of that frame that were output with out_fix=1.
- R9: Cycles with in_valid=0 inside a frame stall the stream and do not change any output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_pix | input | PIX_W | Raw Bayer sample |
| thr_hot | input | PIX_W | Largest allowed rise above the median |
| thr_cold | input | PIX_W | Largest allowed fall below the median |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | PIX_W | Corrected or passed-through sample |
| out_fix | output | 1 | This output was replaced by the median |
| defect_count | output | CNT_W | Number of corrections in the last finished frame |

## Verification
The checker holds on every cycle a number of properties. A correction never appears without a valid output. The count only moves on the cycle that leaves ST_DONE, and it never exceeds the number of interior pixels. Draining only happens once the whole frame has been accepted. No output appears once the block has been idle for more than a cycle.

Whether a pixel is corrected, and with what value, depends on the median of its neighbourhood. Only the bench scenarios can show that. They cover background built from a hash, planes of constant value with pixels placed exactly on each threshold and one step past it, defects on the border, gaps in in_valid, junk input during the drain and while idle, and thresholds set so high that nothing is corrected.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_DRAIN,
        ST_DONE
    } dpc_state_t;
endpackage

// File: rtl/dpc_window.sv
// Four line delays sharing one pointer, feeding a 5x5 register window.
// win[r][c]: r=4 is the newest row, c=4 the newest column.
module dpc_window #(
    parameter int PIX_W = 8,
    parameter int IMG_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         step,
    input  logic [PIX_W-1:0]             din,
    output logic [4:0][4:0][PIX_W-1:0]   win
);
    localparam int PTR_W = $clog2(IMG_W);

    logic [PTR_W-1:0]           ptr;
    logic [4:0][PIX_W-1:0]      col;

    assign col[4] = din;

    for (genvar i = 0; i < 4; i++) begin : g_line
        logic [PIX_W-1:0] mem [IMG_W];
        assign col[3-i] = mem[ptr];
        always_ff @(posedge clk) begin
            if (step) begin
                mem[ptr] <= col[4-i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            win <= '0;
        end else if (step) begin
            ptr <= (ptr == PTR_W'(IMG_W-1)) ? '0 : ptr + 1'b1;
            for (int r = 0; r < 5; r++) begin
                for (int c = 0; c < 4; c++) begin
                    win[r][c] <= win[r][c+1];
                end
                win[r][4] <= col[r];
            end
        end
    end
endmodule

// File: rtl/dpc_median8.sv
// Median of eight: floor of the mean of the 4th and 5th smallest values.
module dpc_median8 #(
    parameter int PIX_W = 8
) (
    input  logic [7:0][PIX_W-1:0] v,
    output logic [PIX_W-1:0]      med
);
    logic [7:0][2:0]   rank;
    logic [PIX_W-1:0]  lo, hi;
    logic [PIX_W:0]    sum;

    always_comb begin
        for (int i = 0; i < 8; i++) begin
            int r;
            r = 0;
            for (int j = 0; j < 8; j++) begin
                if (j != i && (v[j] < v[i] || (v[j] == v[i] && j < i))) begin
                    r++;
                end
            end
            rank[i] = 3'(r);
        end
        lo = '0;
        hi = '0;
        for (int i = 0; i < 8; i++) begin
            if (rank[i] == 3'd3) lo = v[i];
            if (rank[i] == 3'd4) hi = v[i];
        end
        sum = {1'b0, lo} + {1'b0, hi};
        med = sum[PIX_W:1];
    end
endmodule

// File: rtl/dpc_corrector.sv
module dpc_corrector
    import dpc_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int IMG_W = 12,
    parameter int IMG_H = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [PIX_W-1:0] in_pix,
    input  logic [PIX_W-1:0] thr_hot,
    input  logic [PIX_W-1:0] thr_cold,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_fix,
    output logic [CNT_W-1:0] defect_count
);
    localparam int NPIX   = IMG_W * IMG_H;
    localparam int LAT    = 2 * IMG_W + 2;
    localparam int LAST   = NPIX + LAT - 1;
    localparam int STEP_W = $clog2(NPIX + LAT + 1);
    localparam int COL_W  = $clog2(IMG_W + 1);
    localparam int ROW_W  = $clog2(IMG_H + 1);

    dpc_state_t                 state, nstate;
    logic                       step;
    logic [PIX_W-1:0]           din;
    logic [STEP_W-1:0]          step_cnt;
    logic [COL_W-1:0]           cen_col;
    logic [ROW_W-1:0]           cen_row;
    logic                       cen_int, win_ok;
    logic [CNT_W-1:0]           cnt;
    logic [4:0][4:0][PIX_W-1:0] win;
    logic [7:0][PIX_W-1:0]      nb;
    logic [PIX_W-1:0]           ctr, med;
    logic                       hot, cold, fix, interior, centre_now;
    logic [CNT_W-1:0]           fix_inc;

    dpc_window #(.PIX_W(PIX_W), .IMG_W(IMG_W)) u_window (
        .clk(clk), .rst_n(rst_n), .step(step), .din(din), .win(win)
    );

    assign nb = {win[0][0], win[0][2], win[0][4], win[2][0],
                 win[2][4], win[4][0], win[4][2], win[4][4]};

    dpc_median8 #(.PIX_W(PIX_W)) u_median (.v(nb), .med(med));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Transitions: start, last_in, drained, rearm
    always_comb begin
        nstate = state;
        step   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (in_valid && in_sof) begin
                    step   = 1'b1;
                    nstate = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (in_valid) begin
                    step = 1'b1;
                    if (step_cnt == STEP_W'(NPIX-1)) nstate = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                step = 1'b1;
                if (step_cnt == STEP_W'(LAST)) nstate = ST_DONE;
            end
            ST_DONE: nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    assign din        = (state == ST_DRAIN) ? '0 : in_pix;
    assign centre_now = step && (step_cnt >= STEP_W'(LAT));
    assign interior   = (cen_col >= COL_W'(2)) && (cen_col <= COL_W'(IMG_W-3)) &&
                        (cen_row >= ROW_W'(2)) && (cen_row <= ROW_W'(IMG_H-3));

    always_comb begin
        ctr     = win[2][2];
        hot     = (ctr > med) && ((ctr - med) > thr_hot);
        cold    = (med > ctr) && ((med - ctr) > thr_cold);
        fix     = cen_int && (hot || cold);
        fix_inc = CNT_W'(win_ok && fix);
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_cnt     <= '0;
            cen_col      <= '0;
            cen_row      <= '0;
            cen_int      <= 1'b0;
            win_ok       <= 1'b0;
            cnt          <= '0;
            out_valid    <= 1'b0;
            out_fix      <= 1'b0;
            out_pix      <= '0;
            defect_count <= '0;
        end else begin
            win_ok <= centre_now;
            if (state == ST_DONE) begin
                step_cnt <= '0;
                cen_col  <= '0;
                cen_row  <= '0;
            end else begin
                if (step) step_cnt <= step_cnt + 1'b1;
                if (centre_now) begin
                    cen_int <= interior;
                    if (cen_col == COL_W'(IMG_W-1)) begin
                        cen_col <= '0;
                        cen_row <= cen_row + 1'b1;
                    end else begin
                        cen_col <= cen_col + 1'b1;
                    end
                end
            end
            out_valid <= win_ok;
            out_fix   <= win_ok && fix;
            out_pix   <= fix ? med : ctr;
            if (state == ST_DONE) begin
                defect_count <= cnt + fix_inc;
                cnt          <= '0;
            end else begin
                cnt <= cnt + fix_inc;
            end
        end
    end
endmodule

// File: rtl/dpc_corrector_chk.sv
module dpc_corrector_chk
    import dpc_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int IMG_W  = 12,
    parameter int IMG_H  = 8,
    parameter int CNT_W  = 16,
    parameter int STEP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input dpc_state_t        state,
    input logic [STEP_W-1:0] step_cnt,
    input logic              out_valid,
    input logic              out_fix,
    input logic [CNT_W-1:0]  defect_count
);
    localparam int NPIX = IMG_W * IMG_H;
    localparam int NINT = (IMG_W - 4) * (IMG_H - 4);

    p_fix_has_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_fix |-> out_valid);

    p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DONE) |=> $stable(defect_count));

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        defect_count <= CNT_W'(NINT));

    p_drain_after_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> (step_cnt >= STEP_W'(NPIX)));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> !out_valid);
endmodule

bind dpc_corrector dpc_corrector_chk #(
    .PIX_W(PIX_W), .IMG_W(IMG_W), .IMG_H(IMG_H), .CNT_W(CNT_W), .STEP_W(STEP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .step_cnt(step_cnt),
    .out_valid(out_valid), .out_fix(out_fix), .defect_count(defect_count)
);

// File: tb/dpc_corrector_bench.sv
`timescale 1ns/1ps
module dpc_corrector_bench;
    localparam int PW = 8, W = 12, H = 8, CW = 16;
    localparam int LAT = 2 * W + 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0;
    logic [PW-1:0] in_pix = '0, thr_hot = '0, thr_cold = '0;
    logic out_valid, out_fix;
    logic [PW-1:0] out_pix;
    logic [CW-1:0] defect_count;

    int checks = 0, fails = 0, exp_count = 0;
    int img [H][W];
    int q_pix[$], q_fix[$];
    string q_req[$];
    bit finished = 0;

    always #2.5 clk = ~clk;

    dpc_corrector #(.PIX_W(PW), .IMG_W(W), .IMG_H(H), .CNT_W(CW)) u_dpc_corrector (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix),
        .thr_hot(thr_hot), .thr_cold(thr_cold), .out_valid(out_valid), .out_pix(out_pix),
        .out_fix(out_fix), .defect_count(defect_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Model: build the expected output sequence for the current image
    task automatic build_expected(input int th, input int tc);
        exp_count = 0;
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                if (r < 2 || r > H - 3 || c < 2 || c > W - 3) begin
                    q_pix.push_back(img[r][c]); q_fix.push_back(0); q_req.push_back("R6");
                end else begin
                    int a [8];
                    int k, med, t;
                    k = 0;
                    for (int dr = -2; dr <= 2; dr += 2)
                        for (int dc = -2; dc <= 2; dc += 2)
                            if (dr != 0 || dc != 0) begin a[k] = img[r+dr][c+dc]; k++; end
                    for (int i = 0; i < 8; i++)
                        for (int j = 0; j < 7 - i; j++)
                            if (a[j] > a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
                    med = (a[3] + a[4]) / 2;
                    if (img[r][c] - med > th) begin
                        q_pix.push_back(med); q_fix.push_back(1); q_req.push_back("R3"); exp_count++;
                    end else if (med - img[r][c] > tc) begin
                        q_pix.push_back(med); q_fix.push_back(1); q_req.push_back("R4"); exp_count++;
                    end else begin
                        q_pix.push_back(img[r][c]); q_fix.push_back(0); q_req.push_back("R5");
                    end
                end
            end
        end
    endtask

    // Driver: stream a frame (optional gaps, R9), then junk during drain (R7)
    task automatic send_frame(input int th, input int tc, input bit gaps);
        thr_hot = PW'(th); thr_cold = PW'(tc);
        build_expected(th, tc);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                @(negedge clk);
                in_valid = 1'b1; in_sof = (r == 0 && c == 0); in_pix = PW'(img[r][c]);
                if (gaps && ((r * W + c) % 3 == 1)) begin
                    @(negedge clk); in_valid = 1'b0; in_pix = 8'hAA;
                    @(negedge clk);
                end
            end
        end
        for (int i = 0; i < LAT + 3; i++) begin
            @(negedge clk); in_valid = 1'b1; in_sof = 1'b0; in_pix = 8'hFF;
        end
        @(negedge clk); in_valid = 1'b0;
        wait (q_pix.size() == 0);
        repeat (4) @(negedge clk);
        chk(defect_count == CW'(exp_count), "R8", int'(defect_count), exp_count);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_pix.size() == 0) begin
                chk(1'b0, "R2", 1, 0);
            end else begin
                int ep, ef;
                string rq;
                ep = q_pix.pop_front(); ef = q_fix.pop_front(); rq = q_req.pop_front();
                chk(out_pix == PW'(ep), rq, int'(out_pix), ep);
                chk(out_fix == ef[0], rq, int'(out_fix), ef);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(out_fix == 1'b0, "R1", int'(out_fix), 0);
        chk(defect_count == '0, "R1", int'(defect_count), 0);
        rst_n = 1'b1;
        // R7: idle input without start marker must not start a frame
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); in_valid = 1'b1; in_sof = 1'b0; in_pix = 8'h33;
        end
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(defect_count == '0, "R7", int'(defect_count), 0);

        // Frame 1: hashed background, hot/cold interior defects, border defects
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                img[r][c] = (r * 37 + c * 11) % 64 + 40;
        img[4][5] = 250; img[3][3] = 0; img[0][1] = 255; img[7][11] = 0; img[2][1] = 255;
        send_frame(40, 30, 1'b0);

        // Frame 2: constant colour planes, exact threshold edges, with gaps (R9)
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                img[r][c] = 60 + 20 * (r % 2) + 10 * (c % 2);
        img[2][2] = img[2][2] + 25;        // R5 exactly at hot threshold
        img[2][5] = img[2][5] + 26;        // R3 one past
        img[4][4] = img[4][4] - 35;        // R5 exactly at cold threshold
        img[5][7] = img[5][7] - 36;        // R4 one past
        send_frame(25, 35, 1'b1);

        // Frame 3: same image, thresholds at maximum so nothing is replaced
        img[3][6] = 255;
        send_frame(255, 255, 1'b0);
        chk(exp_count == 0, "R5", exp_count, 0);

        chk(q_pix.size() == 0, "R2", q_pix.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule